// File: doc/BRIEF.md
# Triple-Write Clock Frequency Selector

This block holds the master-clock frequency setting of a clock synthesizer. Four input frequencies are possible, and the block comes out of reset set to 20 MHz. The host changes the setting by writing the same ID three times to one control register. No other register may be read or written between those writes. The block watches every access on a simple host bus, which carries an address, write data, a write strobe, a read strobe and registered read data. From these accesses it decides whether the sequence is still intact.

When a qualifying third write lands, the block loads the new frequency ID and raises an internal soft-reset pulse for one cycle. A read of the control register returns three fields:

- the accepted frequency ID,
- the progress of the write sequence,
- the ID that is currently pending.

A read of the control register does not break a sequence. Idle cycles do not break it either.

Top module: `freq_sel_ctrl`

## Requirements
- R1: After reset, freq_id_o is 3, soft_rst_o is 0, rdata_o is 0, and the write count and the pending ID are both 0.
- R2: The frequency ID is the 2-bit field wdata_i[1:0]. Its codes are 0 = 10 MHz, 1 = 12.8 MHz, 2 = 19.2 MHz and 3 = 20 MHz. All higher bits of wdata_i are ignored.
- R3: On the clock edge of the third consecutive write of one ID to address SEL_ADDR (default 0x10), freq_id_o takes that ID on the following cycle. In that same cycle, soft_rst_o is high for exactly one cycle.
- R4: One or two qualifying writes leave freq_id_o unchanged and keep soft_rst_o low.
- R5: A read or write to any address other than SEL_ADDR clears the write count to 0 and the pending ID to 0.
- R6: A write to SEL_ADDR whose ID differs from the pending ID restarts the sequence. The count becomes 1 and the pending ID becomes the new ID. The first write after the count reaches 0 also sets the count to 1.
- R7: A read of SEL_ADDR leaves the count and the pending ID unchanged.
- R8: A read of SEL_ADDR returns rdata_o on the next cycle with these fields, taken from the state before that edge:
  - bits [1:0] hold the accepted ID,
  - bits [5:4] hold the count,
  - bits [9:8] hold the pending ID,
  - all other bits are 0.

  In every other cycle rdata_o is 0.
- R9: The count returns to 0 on a commit. The pending ID keeps the committed value, so the next commit needs three new writes.
- R10: Idle cycles, with neither strobe high, do not disturb the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data; bits [1:0] carry the ID |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Registered read data |
| freq_id_o | output | 2 | Accepted frequency ID |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse |

## Verification
The bench looks for the following faults:

- **Fourth commit.** A design that counts total writes rather than consecutive matching ones would commit after a changed ID. The bench therefore changes the ID partway through a sequence.
- **Read breaks the sequence.** Own-register reads are interleaved with the writes. A design that treats all reads as foreign would never commit.
- **Foreign access ignored.** Foreign reads and foreign writes are placed just before the third write. A design that resets only on foreign writes, or not at all, would commit too early.
- **Wrong pulse or readback timing.** The reference model is compared on every clock. This catches a stretched pulse, a missing return of the count to 0, and readback fields in the wrong bit positions or with the wrong timing.

// File: rtl/freq_sel_pkg.sv
package freq_sel_pkg;
  localparam int ID_W = 2;
  localparam int RB_FREQ_LSB = 0;
  localparam int RB_CNT_LSB  = 4;
  localparam int RB_PEND_LSB = 8;

  typedef enum logic [ID_W-1:0] {
    FREQ_10M0 = 2'd0,
    FREQ_12M8 = 2'd1,
    FREQ_19M2 = 2'd2,
    FREQ_20M0 = 2'd3
  } freq_id_e;

  typedef struct packed {
    logic own_wr;
    logic own_rd;
    logic foreign;
  } acc_t;
endpackage

// File: rtl/fsel_decode.sv
module fsel_decode
  import freq_sel_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output acc_t              acc_o
);
  logic hit;
  assign hit = (addr_i == SEL_ADDR);

  always_comb begin
    acc_o.own_wr  = wr_i & hit;
    acc_o.own_rd  = rd_i & hit;
    acc_o.foreign = (wr_i | rd_i) & ~hit;
  end
endmodule

// File: rtl/fsel_seq.sv
module fsel_seq
  import freq_sel_pkg::*;
#(
  parameter int WRITES_NEEDED = 3,
  localparam int CNT_W = $clog2(WRITES_NEEDED + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  acc_t             acc_i,
  input  freq_id_e         wr_id_i,
  output logic [CNT_W-1:0] cnt_o,
  output freq_id_e         pend_o,
  output logic             commit_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WRITES_NEEDED - 1);

  logic [CNT_W-1:0] cnt_q;
  freq_id_e         pend_q;
  logic             match;

  assign match    = (cnt_q != '0) && (wr_id_i == pend_q);
  assign commit_o = acc_i.own_wr && match && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= FREQ_10M0;
    end else if (acc_i.foreign) begin
      cnt_q  <= '0;
      pend_q <= FREQ_10M0;
    end else if (acc_i.own_wr) begin
      if (!match) begin
        cnt_q  <= CNT_W'(1);
        pend_q <= wr_id_i;
      end else if (commit_o) begin
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/fsel_commit.sv
module fsel_commit
  import freq_sel_pkg::*;
#(
  parameter freq_id_e RESET_ID = FREQ_20M0
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     commit_i,
  input  freq_id_e id_i,
  output freq_id_e freq_o,
  output logic     soft_rst_o
);
  freq_id_e freq_q;
  logic     soft_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_q <= RESET_ID;
      soft_q <= 1'b0;
    end else begin
      soft_q <= commit_i;
      if (commit_i) freq_q <= id_i;
    end
  end

  assign freq_o     = freq_q;
  assign soft_rst_o = soft_q;
endmodule

// File: rtl/fsel_readback.sv
module fsel_readback
  import freq_sel_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  freq_id_e          freq_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  freq_id_e          pend_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    word = '0;
    word[RB_FREQ_LSB +: ID_W]  = freq_i;
    word[RB_CNT_LSB  +: CNT_W] = cnt_i;
    word[RB_PEND_LSB +: ID_W]  = pend_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_i ? word : '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/freq_sel_ctrl.sv
module freq_sel_ctrl
  import freq_sel_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h10,
  parameter int WRITES_NEEDED = 3,
  localparam int CNT_W = $clog2(WRITES_NEEDED + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ID_W-1:0]   freq_id_o,
  output logic              soft_rst_o
);
  acc_t             acc;
  freq_id_e         wr_id;
  freq_id_e         pend_id;
  freq_id_e         freq_id;
  logic [CNT_W-1:0] seq_cnt;
  logic             commit;
  logic             unused_wdata;

  assign wr_id        = freq_id_e'(wdata_i[ID_W-1:0]);
  assign unused_wdata = ^wdata_i[DATA_W-1:ID_W];

  fsel_decode #(.ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR)) u_decode (
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .rd_i   (rd_i),
    .acc_o  (acc)
  );

  fsel_seq #(.WRITES_NEEDED(WRITES_NEEDED)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_i    (acc),
    .wr_id_i  (wr_id),
    .cnt_o    (seq_cnt),
    .pend_o   (pend_id),
    .commit_o (commit)
  );

  fsel_commit #(.RESET_ID(FREQ_20M0)) u_commit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .commit_i   (commit),
    .id_i       (wr_id),
    .freq_o     (freq_id),
    .soft_rst_o (soft_rst_o)
  );

  fsel_readback #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (acc.own_rd),
    .freq_i  (freq_id),
    .cnt_i   (seq_cnt),
    .pend_i  (pend_id),
    .rdata_o (rdata_o)
  );

  assign freq_id_o = freq_id;
endmodule

// File: rtl/fsel_checker.sv
module fsel_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h10,
  parameter int CNT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [1:0]        freq_id_o,
  input logic              soft_rst_o,
  input logic [CNT_W-1:0]  cnt_i
);
  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);

  a_r3_pulse_after_own_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> $past(wr_i && addr_i == SEL_ADDR));

  a_r4_freq_moves_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(freq_id_o) |-> soft_rst_o);

  a_r5_foreign_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_i || rd_i) && addr_i != SEL_ADDR) |=> cnt_i == '0);

  a_r7_own_read_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == SEL_ADDR) |=> $stable(cnt_i));

  a_r8_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && addr_i == SEL_ADDR) |=> rdata_o == '0);

  a_r9_count_zero_on_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> cnt_i == '0);
endmodule

bind freq_sel_ctrl fsel_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_ADDR(SEL_ADDR), .CNT_W(CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .rdata_o    (rdata_o),
  .freq_id_o  (freq_id_o),
  .soft_rst_o (soft_rst_o),
  .cnt_i      (seq_cnt)
);

// File: tb/freq_sel_ctrl_bench.sv
`timescale 1ns/1ps
module freq_sel_ctrl_bench;
  localparam logic [7:0] SEL = 8'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] rdata;
  logic [1:0]  freq_id;
  logic        soft_rst;

  int checks = 0;
  int failures = 0;

  int m_freq = 3, m_cnt = 0, m_pend = 0, m_soft = 0, m_rdata = 0;

  always #2.5 clk = ~clk;

  freq_sel_ctrl u_freq_sel_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .freq_id_o(freq_id),
    .soft_rst_o(soft_rst)
  );

  task automatic compare(input string tag);
    checks++;
    if (rdata !== 32'(m_rdata) || freq_id !== 2'(m_freq) || soft_rst !== 1'(m_soft)) begin
      failures++;
      $display("FAIL %s: rdata=%h freq=%0d soft=%0d expected rdata=%h freq=%0d soft=%0d",
               tag, rdata, freq_id, soft_rst, m_rdata, m_freq, m_soft);
    end
  endtask

  task automatic cyc(input bit w, input bit r, input logic [7:0] a,
                     input logic [31:0] d, input string tag);
    int id;
    wr = w; rd = r; addr = a; wdata = d;
    @(posedge clk);
    m_soft = 0;
    m_rdata = (r && a == SEL) ? ((m_pend << 8) | (m_cnt << 4) | m_freq) : 0;
    if ((w || r) && a != SEL) begin
      m_cnt = 0; m_pend = 0;
    end else if (w) begin
      id = int'(d[1:0]);
      if (m_cnt == 0 || id != m_pend) begin
        m_cnt = 1; m_pend = id;
      end else begin
        m_cnt++;
        if (m_cnt == 3) begin
          m_freq = m_pend; m_soft = 1; m_cnt = 0;
        end
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wsel(input logic [31:0] d, input string tag);
    cyc(1, 0, SEL, d, tag);
  endtask
  task automatic rsel(input string tag);
    cyc(0, 1, SEL, '0, tag);
  endtask
  task automatic idle(input string tag);
    cyc(0, 0, '0, '0, tag);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");
    rsel("R1 readback");
    idle("R1 readback data");

    // R3 / R2: commit ID 0 (10 MHz), pulse one cycle
    wsel(32'h0, "R3 w1"); wsel(32'h0, "R4 w2"); wsel(32'h0, "R3 commit");
    idle("R3 pulse ends");
    rsel("R9 count zero"); idle("R9 readback");

    // R2: upper data bits ignored, ID 2
    wsel(32'hFFFF_FFF2, "R2 w1"); rsel("R7 read mid");
    idle("R10 idle"); idle("R10 idle");
    wsel(32'h0000_1002, "R2 w2"); rsel("R8 count two");
    wsel(32'hA5A5_A5A6, "R2 commit"); idle("R3 pulse ends");

    // R5: foreign read and write before third write
    wsel(32'h1, "R5 w1"); wsel(32'h1, "R5 w2");
    cyc(0, 1, 8'h11, '0, "R5 foreign read");
    rsel("R5 cleared"); idle("R8 readback");
    wsel(32'h1, "R5 restart1"); wsel(32'h1, "R5 restart2");
    cyc(1, 0, 8'h04, 32'h1, "R5 foreign write");
    wsel(32'h1, "R5 no commit"); rsel("R5 count one");

    // R6: differing ID restarts
    wsel(32'h3, "R6 change"); wsel(32'h3, "R6 w2"); rsel("R6 count two");
    wsel(32'h1, "R6 restart"); wsel(32'h1, "R6 w2b"); wsel(32'h1, "R6 commit");
    idle("R6 idle");

    // R9: back-to-back sequences, fresh three writes required
    wsel(32'h3, "R9 a1"); wsel(32'h3, "R9 a2"); wsel(32'h3, "R9 commit a");
    wsel(32'h3, "R9 b1"); wsel(32'h3, "R9 b2"); rsel("R9 no early");
    wsel(32'h3, "R9 commit b"); idle("R9 idle");
    for (int i = 0; i < 4; i++) begin
      wsel(32'(i), "R2 sweep"); wsel(32'(i), "R2 sweep");
      wsel(32'(i), "R2 sweep commit"); rsel("R8 sweep read"); idle("R8 sweep data");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule